// File: doc/BRIEF.md
# Serial shift unit with clock counter and line-condition flags

This block is an eight-bit shift engine for small controllers. It moves bytes over a three-wire synchronous link or a two-wire open-drain bus. The processor reaches three registers through a select/write/read port: the shift register itself, a read-only capture register, and a status word. There is no staging register in front of the shift register. A processor write lands directly in the shifter, and a write in the same cycle as a clock event takes priority over the shift.

Shifting is driven by one of four clock sources: a software strobe, a timer compare pulse, the rising edge of the serial clock pin, or the falling edge of that pin. A four-bit counter advances on every clock event. With an external source it counts both pin edges. When the counter wraps, the unit raises an overflow flag and captures the shifter contents. The serial output takes the shifter MSB through a hold latch, so that output changes and input sampling fall on opposite pin edges.

In two-wire mode the unit reports bus start and stop conditions, and it flags a mismatch between the driven bit and the bus level. In three-wire mode with a pin clock source, any pin edge raises the start flag.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, the data, capture and status reads all return 0x00 and `serOut` is 0.
- R2: Register select 0 reads and writes the shift register directly. Select 1 reads the capture register, and writes to it are ignored. Select 2 is the status word. Select 3 reads 0x00.
- R3: On each shift event the register moves one place toward the MSB and takes the serial input into bit 0. The serial input is `sdaIn` when `twoWire` is 1 and `dataIn` otherwise. The `clkSrc` encoding is:
  - 0: a `swStrobe` pulse.
  - 1: a `timerMatch` pulse.
  - 2: sampling on the rising edge of `sclIn`.
  - 3: sampling on the falling edge of `sclIn`.
- R4: A processor write to the shift register in the same cycle as a shift event leaves the written value, and that shift is lost.
- R5: With an internal source (`clkSrc` 0 or 1), `serOut` always follows the shifter MSB. With a pin source, `serOut` follows the MSB only between the output edge and the sampling edge. From the sampling edge to the next output edge it holds the MSB present at the sampling edge, even across processor writes.
- R6: The status word is laid out as follows:
  - bit 7: start flag.
  - bit 6: overflow flag.
  - bit 5: stop flag.
  - bit 4: bus mismatch.
  - bits 3..0: the counter.
  The counter advances by one per clock event, and on both `sclIn` edges with a pin source. A status write loads the counter from write bits 3..0, and this load takes priority over a same-cycle count.
- R7: When the counter wraps from 15 to 0, the overflow flag is set and the capture register takes the shift register value produced in that cycle.
- R8: A status write clears each flag whose bit position carries a 1 and leaves alone each flag whose bit carries a 0.
- R9: In two-wire mode, `sdaIn` falling while `sclIn` stays high sets the start flag. `sdaIn` rising while `sclIn` stays high sets the stop flag. Changes of `sdaIn` while `sclIn` is low set neither flag.
- R10: In three-wire mode with a pin source, every `sclIn` edge sets the start flag. With an internal source, `sclIn` edges set no flag and do not move the counter.
- R11: Status bit 4 reads 1 exactly when `twoWire` is 1 and `serOut` differs from `sdaIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 shift, 1 capture, 2 status |
| wrEn | input | 1 | Processor write strobe |
| wrData | input | 8 | Processor write data |
| rdData | output | 8 | Processor read data, combinational from `regSel` |
| twoWire | input | 1 | 1 selects two-wire bus mode, 0 three-wire |
| clkSrc | input | 2 | Clock source select |
| swStrobe | input | 1 | Software clock pulse |
| timerMatch | input | 1 | Timer compare pulse |
| dataIn | input | 1 | Three-wire serial data input |
| sdaIn | input | 1 | Two-wire bus data level |
| sclIn | input | 1 | Serial clock pin level |
| serOut | output | 1 | Serial data output after the hold latch |

## Verification
The hardest situations to reach are those where two things meet in one cycle. One is a processor write landing on the same cycle as a shift or count event. Another is an MSB rewrite while the output latch is closed. The bench raises `wrEn` and `swStrobe` on the same clock to create the collisions. It writes a new MSB between a rising pin edge and the next falling edge, so that the held bit and the register bit differ at the pin. Bus start and stop conditions are produced by moving `sdaIn` alone while `sclIn` is held high, and then again with `sclIn` low to show that nothing is flagged.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_BUF  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam logic [1:0] CS_SOFT     = 2'd0;
  localparam logic [1:0] CS_TIMER    = 2'd1;
  localparam logic [1:0] CS_EXT_RISE = 2'd2;
  localparam logic [1:0] CS_EXT_FALL = 2'd3;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftEv;
    logic countEv;
    logic startSet;
    logic stopSet;
    logic latchOpen;
  } ssu_strobe_t;
endpackage

// File: rtl/ssu_ctrl.sv
module ssu_ctrl
  import ssu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  clkSrc,
  input  logic        twoWire,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        swStrobe,
  input  logic        timerMatch,
  output ssu_strobe_t strb
);
  logic sclQ, sdaQ;
  logic extSrc, sclRise, sclFall, sclEdge, sampleEdge, internalEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b0;
      sdaQ <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign extSrc     = clkSrc[1];
  assign sclRise    = sclIn & ~sclQ;
  assign sclFall    = ~sclIn & sclQ;
  assign sclEdge    = sclRise | sclFall;
  assign sampleEdge = (clkSrc == CS_EXT_FALL) ? sclFall : sclRise;
  assign internalEv = ((clkSrc == CS_SOFT) & swStrobe) |
                      ((clkSrc == CS_TIMER) & timerMatch);

  always_comb begin
    strb.shiftEv  = extSrc ? sampleEdge : internalEv;
    strb.countEv  = extSrc ? sclEdge : internalEv;
    // bus conditions need SCL high on both sides of the SDA change
    strb.startSet = twoWire ? (sclIn & sclQ & sdaQ & ~sdaIn) : (extSrc & sclEdge);
    strb.stopSet  = twoWire & sclIn & sclQ & ~sdaQ & sdaIn;
    // open from the output edge until the sampling edge
    strb.latchOpen = ~extSrc | (sclQ == clkSrc[0]);
  end
endmodule

// File: rtl/ssu_datapath.sv
module ssu_datapath
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssu_strobe_t       strb,
  input  logic              dataWr,
  input  logic              statWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serIn,
  input  logic              sdaIn,
  input  logic              twoWire,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] bufQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic              startFlag,
  output logic              ovfFlag,
  output logic              stopFlag,
  output logic              collision,
  output logic              serOut
);
  localparam int MSB       = DATA_W - 1;
  localparam int START_POS = DATA_W - 1;
  localparam int OVF_POS   = DATA_W - 2;
  localparam int STOP_POS  = DATA_W - 3;

  logic [DATA_W-1:0] shiftNext;
  logic wrap, holdQ;
  logic clrStart, clrOvf, clrStop;

  always_comb begin
    shiftNext = dataQ;
    if (dataWr)            shiftNext = wrData;
    else if (strb.shiftEv) shiftNext = {dataQ[MSB-1:0], serIn};
  end

  assign wrap     = strb.countEv & ~statWr & (&cntQ);
  assign clrStart = statWr & wrData[START_POS];
  assign clrOvf   = statWr & wrData[OVF_POS];
  assign clrStop  = statWr & wrData[STOP_POS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ     <= '0;
      bufQ      <= '0;
      cntQ      <= '0;
      startFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      stopFlag  <= 1'b0;
      holdQ     <= 1'b0;
    end else begin
      dataQ <= shiftNext;
      if (wrap) bufQ <= shiftNext;
      if (statWr)            cntQ <= wrData[CNT_W-1:0];
      else if (strb.countEv) cntQ <= cntQ + 1'b1;
      startFlag <= strb.startSet | (startFlag & ~clrStart);
      ovfFlag   <= wrap          | (ovfFlag & ~clrOvf);
      stopFlag  <= strb.stopSet  | (stopFlag & ~clrStop);
      if (strb.latchOpen) holdQ <= dataQ[MSB];
    end
  end

  assign serOut    = strb.latchOpen ? dataQ[MSB] : holdQ;
  assign collision = twoWire & (serOut != sdaIn);
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              twoWire,
  input  logic [1:0]        clkSrc,
  input  logic              swStrobe,
  input  logic              timerMatch,
  input  logic              dataIn,
  input  logic              sdaIn,
  input  logic              sclIn,
  output logic              serOut
);
  localparam int CNT_W = $clog2(2 * DATA_W);

  ssu_strobe_t       strb;
  logic [DATA_W-1:0] dataQ, bufQ, statusWord;
  logic [CNT_W-1:0]  cntQ;
  logic startFlag, ovfFlag, stopFlag, collision;
  logic dataWr, statWr, serIn;

  assign dataWr = wrEn & (regSel == SEL_DATA);
  assign statWr = wrEn & (regSel == SEL_STAT);
  assign serIn  = twoWire ? sdaIn : dataIn;

  ssu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkSrc(clkSrc), .twoWire(twoWire),
    .sclIn(sclIn), .sdaIn(sdaIn), .swStrobe(swStrobe),
    .timerMatch(timerMatch), .strb(strb)
  );

  ssu_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataWr(dataWr), .statWr(statWr),
    .wrData(wrData), .serIn(serIn), .sdaIn(sdaIn), .twoWire(twoWire),
    .dataQ(dataQ), .bufQ(bufQ), .cntQ(cntQ), .startFlag(startFlag),
    .ovfFlag(ovfFlag), .stopFlag(stopFlag), .collision(collision),
    .serOut(serOut)
  );

  always_comb begin
    statusWord = '0;
    statusWord[DATA_W-1] = startFlag;
    statusWord[DATA_W-2] = ovfFlag;
    statusWord[DATA_W-3] = stopFlag;
    statusWord[DATA_W-4] = collision;
    statusWord[CNT_W-1:0] = cntQ;
  end

  always_comb begin
    case (regSel)
      SEL_DATA: rdData = dataQ;
      SEL_BUF:  rdData = bufQ;
      SEL_STAT: rdData = statusWord;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input ssu_strobe_t       strb,
  input logic              dataWr,
  input logic              statWr,
  input logic [DATA_W-1:0] wrData,
  input logic              serIn,
  input logic [DATA_W-1:0] dataQ,
  input logic [DATA_W-1:0] bufQ,
  input logic [CNT_W-1:0]  cntQ,
  input logic              startFlag,
  input logic              ovfFlag,
  input logic              stopFlag,
  input logic              serOut
);
  assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && strb.shiftEv |=> dataQ == $past(wrData));

  assert_shift_left_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEv && !dataWr |=> dataQ == {$past(dataQ[DATA_W-2:0]), $past(serIn)});

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.countEv && !statWr |=> cntQ == CNT_W'($past(cntQ) + 1'b1));

  assert_count_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    statWr |=> cntQ == $past(wrData[CNT_W-1:0]));

  assert_wrap_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.countEv && !statWr && (&cntQ) |=> ovfFlag && bufQ == dataQ);

  assert_buffer_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.countEv && !statWr && (&cntQ)) |=> $stable(bufQ));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.latchOpen) && !strb.latchOpen |-> $stable(serOut));

  assert_latch_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchOpen |-> serOut == dataQ[DATA_W-1]);

  assert_start_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.startSet |=> startFlag);

  assert_stop_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopSet |=> stopFlag);
endmodule

bind serial_shift_unit ssu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .dataWr(dataWr), .statWr(statWr),
  .wrData(wrData), .serIn(serIn), .dataQ(dataQ), .bufQ(bufQ), .cntQ(cntQ),
  .startFlag(startFlag), .ovfFlag(ovfFlag), .stopFlag(stopFlag),
  .serOut(serOut)
);

// File: tb/tb_serial_shift_unit.sv
`timescale 1ns/1ps
module tb_serial_shift_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic twoWire = 1'b0;
  logic [1:0] clkSrc = 2'd0;
  logic swStrobe = 1'b0, timerMatch = 1'b0;
  logic dataIn = 1'b0, sdaIn = 1'b0, sclIn = 1'b0;
  logic serOut;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  serial_shift_unit dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .twoWire(twoWire), .clkSrc(clkSrc), .swStrobe(swStrobe),
    .timerMatch(timerMatch), .dataIn(dataIn), .sdaIn(sdaIn), .sclIn(sclIn),
    .serOut(serOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    @(negedge clk); regSel = sel; #1 val = rdData;
  endtask

  task automatic strobe();
    @(negedge clk); swStrobe = 1'b1;
    @(negedge clk); swStrobe = 1'b0;
  endtask

  task automatic setScl(input logic b);
    @(negedge clk); sclIn = b;
    @(negedge clk);
  endtask

  task automatic setSda(input logic b);
    @(negedge clk); sdaIn = b;
    @(negedge clk);
  endtask

  task automatic checkOut(input string req, input logic exp);
    @(negedge clk); #1 check(req, {7'b0, serOut}, {7'b0, exp});
  endtask

  task automatic t_reset();
    rd(2'd0, v); check("R1 data", v, 8'h00);
    rd(2'd1, v); check("R1 capture", v, 8'h00);
    rd(2'd2, v); check("R1 status", v, 8'h00);
    checkOut("R1 serOut", 1'b0);
  endtask

  task automatic t_regs();
    wr(2'd0, 8'hA5); rd(2'd0, v); check("R2 data rw", v, 8'hA5);
    wr(2'd1, 8'h3C); rd(2'd1, v); check("R2 capture ignores write", v, 8'h00);
    rd(2'd3, v); check("R2 unused select", v, 8'h00);
  endtask

  task automatic t_internal_shift();
    clkSrc = 2'd0; twoWire = 1'b0;
    wr(2'd2, 8'hE0);
    wr(2'd0, 8'h81); dataIn = 1'b1; strobe();
    rd(2'd0, v); check("R3 strobe shift", v, 8'h03);
    rd(2'd2, v); check("R6 count one", v, 8'h01);
    clkSrc = 2'd1; dataIn = 1'b0;
    @(negedge clk); timerMatch = 1'b1;
    @(negedge clk); timerMatch = 1'b0;
    rd(2'd0, v); check("R3 timer shift", v, 8'h06);
    rd(2'd2, v); check("R6 count two", v, 8'h02);
  endtask

  task automatic t_collide();
    clkSrc = 2'd0; dataIn = 1'b1;
    @(negedge clk); regSel = 2'd0; wrData = 8'h5A; wrEn = 1'b1; swStrobe = 1'b1;
    @(negedge clk); wrEn = 1'b0; swStrobe = 1'b0;
    rd(2'd0, v); check("R4 write beats shift", v, 8'h5A);
    @(negedge clk); regSel = 2'd2; wrData = 8'h05; wrEn = 1'b1; swStrobe = 1'b1;
    @(negedge clk); wrEn = 1'b0; swStrobe = 1'b0;
    rd(2'd2, v); check("R6 load beats count", v, 8'h05);
  endtask

  task automatic t_overflow();
    logic [7:0] pat = 8'hC9;
    clkSrc = 2'd0; twoWire = 1'b0;
    wr(2'd2, 8'hE8);
    wr(2'd0, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      dataIn = pat[i];
      strobe();
    end
    rd(2'd0, v); check("R3 byte shifted in", v, 8'hC9);
    rd(2'd1, v); check("R7 capture on wrap", v, 8'hC9);
    rd(2'd2, v); check("R7 overflow flag", v, 8'h40);
    wr(2'd2, 8'h00); rd(2'd2, v); check("R8 zero leaves flag", v, 8'h40);
    wr(2'd2, 8'h40); rd(2'd2, v); check("R8 one clears flag", v, 8'h00);
  endtask

  task automatic t_pin_clock();
    twoWire = 1'b0; clkSrc = 2'd2; dataIn = 1'b0;
    wr(2'd2, 8'hE0);
    wr(2'd0, 8'h80);
    checkOut("R5 open before edge", 1'b1);
    setScl(1'b1);
    rd(2'd0, v); check("R3 rising sample", v, 8'h00);
    checkOut("R5 held after sample edge", 1'b1);
    wr(2'd0, 8'h7F);
    checkOut("R5 held across write", 1'b1);
    setScl(1'b0);
    checkOut("R5 reopens on output edge", 1'b0);
    rd(2'd2, v); check("R10 edge sets start, R6 both edges", v, 8'h82);
    wr(2'd2, 8'hE0);
    wr(2'd0, 8'h00); clkSrc = 2'd3; dataIn = 1'b1;
    setScl(1'b1);
    rd(2'd0, v); check("R3 no shift on rise", v, 8'h00);
    setScl(1'b0);
    rd(2'd0, v); check("R3 falling sample", v, 8'h01);
    rd(2'd2, v); check("R6 falling mode count", v, 8'h82);
    clkSrc = 2'd1;
    wr(2'd2, 8'hE0);
    setScl(1'b1); setScl(1'b0);
    rd(2'd2, v); check("R10 internal ignores pin", v, 8'h00);
  endtask

  task automatic t_two_wire();
    clkSrc = 2'd0; twoWire = 1'b1; dataIn = 1'b0;
    setSda(1'b1); setScl(1'b1);
    wr(2'd0, 8'h80);
    wr(2'd2, 8'hE0);
    rd(2'd2, v); check("R11 levels agree", v, 8'h00);
    setSda(1'b0);
    rd(2'd2, v); check("R9 start, R11 mismatch", v, 8'h90);
    setSda(1'b1);
    rd(2'd2, v); check("R9 stop", v, 8'hA0);
    wr(2'd2, 8'hE0);
    setScl(1'b0); setSda(1'b0);
    rd(2'd2, v); check("R9 no flag with clock low", v, 8'h10);
    setSda(1'b1);
    strobe();
    rd(2'd0, v); check("R3 two-wire input", v, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_internal_shift();
    t_collide();
    t_overflow();
    t_pin_clock();
    t_two_wire();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule